// File: doc/BRIEF.md
# Wide Fixed-Point Tiled Multiplier

This block multiplies two 384-bit unsigned fixed-point numbers that share an implied scale of 2^335. Each operand is cut into three 128-bit tiles. A sequencer walks the nine tile pairs and issues one 128x128 partial product per cycle. Each partial product is shifted into place and added into a 768-bit accumulator. When the last pair has been added, the full product is cut at bit 335. The bits above the cut form the scaled quotient and the bits below it form the exact remainder, so no divider and no rounding are involved.

Operands enter through a valid/ready handshake. `in_ready` is high whenever no multiply is in flight. A transfer takes place on a rising edge where both `in_valid` and `in_ready` are high. While a multiply runs, `in_ready` is low and the block applies back-pressure, so `in_valid` and the operand pins have no effect until it rises again. The result side has no back-pressure. `out_done` pulses for one cycle when the result is complete, and the result pins then hold their value until the next accepted operation. A consumer that needs the result later may read it at any point before it issues a new request.

Top module: `wide_fx_mul`

## Requirements
- R1: `in_ready` is high after reset and whenever idle. It goes low for exactly the 9 cycles after an accepting edge and is high again in the cycle in which `out_done` is high.
- R2: `in_valid` and the operand pins are ignored while `in_ready` is low. A request held during a multiply neither changes its result nor starts a second operation.
- R3: `out_done` is high for exactly one cycle, which is the 10th cycle after the accepting edge (9 accumulation cycles, then the result). It is low at all other times.
- R4: When `out_done` is high, `out_quot` equals bits 718 down to 335 of the exact 768-bit product `in_a * in_b`.
- R5: When `out_done` is high, `out_rem` equals bits 334 down to 0 of the exact product.
- R6: When `out_done` is high, `out_ovf` is 1 exactly when any product bit from 719 to 767 is nonzero, meaning the quotient does not fit in 384 bits.
- R7: After `out_done`, `out_quot`, `out_rem` and `out_ovf` stay unchanged until the next accepted request.
- R8: During and right after reset, `in_ready` is 1, and `out_done`, `out_quot`, `out_rem` and `out_ovf` are all 0.
- R9: A request presented in the same cycle as `out_done` is accepted on that edge, and its result follows 10 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_a | input | 384 | Multiplicand, unsigned, scale 2^335 |
| in_b | input | 384 | Multiplier, unsigned, scale 2^335 |
| out_done | output | 1 | One-cycle pulse: result is valid |
| out_quot | output | 384 | Product bits 718..335 (scaled result) |
| out_rem | output | 335 | Product bits 334..0 (remainder) |
| out_ovf | output | 1 | Product bits 767..719 not all zero |

## Verification
Two pairs of events can land in the same cycle.

- **Completion and a new request.** The result pulse and a new request can coincide. The bench issues a second request during the `out_done` cycle of the first. It then checks that the first result was correct in that cycle and that the second result arrives exactly ten cycles later.
- **Accumulation and an offered request.** An accumulation step and a rejected request can coincide. The bench holds `in_valid` high with different operands on every busy cycle. It then checks that `in_ready` stayed low, that no extra `out_done` appeared, and that the returned result matches the operands that were originally accepted.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wfm_seq.sv
module wfm_seq #(
  parameter int NT = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          step,
  output logic          done,
  output logic [IW-1:0] idx_i,
  output logic [IW-1:0] idx_j
);
  import wfm_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NT - 1);

  seq_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      idx_i <= '0;
      idx_j <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st    <= SEQ_RUN;
            idx_i <= '0;
            idx_j <= '0;
          end
        end
        SEQ_RUN: begin
          if (idx_j == LAST) begin
            idx_j <= '0;
            if (idx_i == LAST) begin
              st   <= SEQ_IDLE;
              done <= 1'b1;
            end else begin
              idx_i <= idx_i + 1'b1;
            end
          end else begin
            idx_j <= idx_j + 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (st == SEQ_RUN);
  assign step = busy;
endmodule

// File: rtl/wfm_tile_mac.sv
module wfm_tile_mac #(
  parameter int OP_W   = 384,
  parameter int TILE_W = 128,
  parameter int NT     = 3,
  parameter int IW     = 2,
  parameter int PW     = 768
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] a_in,
  input  logic [OP_W-1:0] b_in,
  input  logic            step,
  input  logic [IW-1:0]   idx_i,
  input  logic [IW-1:0]   idx_j,
  output logic [PW-1:0]   acc
);
  localparam int PPW   = 2 * TILE_W;
  localparam int NPOS  = 2 * NT - 1;

  logic [OP_W-1:0]   a_q, b_q;
  logic [TILE_W-1:0] a_sel, b_sel;
  logic [PPW-1:0]    pp;
  logic [PW-1:0]     pp_ext, shifted;
  logic [IW:0]       pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  always_comb begin
    a_sel = '0;
    b_sel = '0;
    for (int g = 0; g < NT; g++) begin
      if (idx_i == IW'(g)) a_sel = a_q[g*TILE_W +: TILE_W];
      if (idx_j == IW'(g)) b_sel = b_q[g*TILE_W +: TILE_W];
    end
  end

  assign pp     = {{TILE_W{1'b0}}, a_sel} * {{TILE_W{1'b0}}, b_sel};
  assign pp_ext = PW'(pp);
  assign pos    = {1'b0, idx_i} + {1'b0, idx_j};

  always_comb begin
    shifted = '0;
    for (int s = 0; s < NPOS; s++) begin
      if (pos == (IW+1)'(s)) shifted = pp_ext << (s * TILE_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= '0;
    end else if (step) begin
      acc <= acc + shifted;
    end
  end
endmodule

// File: rtl/wfm_split.sv
module wfm_split #(
  parameter int PW     = 768,
  parameter int OP_W   = 384,
  parameter int FRAC_W = 335
) (
  input  logic [PW-1:0]     prod,
  output logic [OP_W-1:0]   quot,
  output logic [FRAC_W-1:0] rem,
  output logic              ovf
);
  localparam int TOP = FRAC_W + OP_W;

  assign quot = prod[TOP-1:FRAC_W];
  assign rem  = prod[FRAC_W-1:0];

  generate
    if (PW > TOP) begin : g_ovf
      assign ovf = |prod[PW-1:TOP];
    end else begin : g_no_ovf
      assign ovf = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wide_fx_mul.sv
module wide_fx_mul #(
  parameter int OP_W   = 384,
  parameter int TILE_W = 128,
  parameter int FRAC_W = 335
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_done,
  output logic [OP_W-1:0]   out_quot,
  output logic [FRAC_W-1:0] out_rem,
  output logic              out_ovf
);
  localparam int NT = OP_W / TILE_W;
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;
  localparam int PW = 2 * OP_W;

  logic          busy, step, accept;
  logic [IW-1:0] idx_i, idx_j;
  logic [PW-1:0] acc;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  wfm_seq #(.NT(NT), .IW(IW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .step  (step),
    .done  (out_done),
    .idx_i (idx_i),
    .idx_j (idx_j)
  );

  wfm_tile_mac #(
    .OP_W(OP_W), .TILE_W(TILE_W), .NT(NT), .IW(IW), .PW(PW)
  ) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .a_in  (in_a),
    .b_in  (in_b),
    .step  (step),
    .idx_i (idx_i),
    .idx_j (idx_j),
    .acc   (acc)
  );

  wfm_split #(.PW(PW), .OP_W(OP_W), .FRAC_W(FRAC_W)) u_split (
    .prod (acc),
    .quot (out_quot),
    .rem  (out_rem),
    .ovf  (out_ovf)
  );
endmodule

// File: rtl/wfm_chk.sv
module wfm_chk #(
  parameter int OP_W   = 384,
  parameter int TILE_W = 128,
  parameter int FRAC_W = 335
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_done,
  input logic [OP_W-1:0]   out_quot,
  input logic [FRAC_W-1:0] out_rem,
  input logic              out_ovf
);
  localparam int NT   = OP_W / TILE_W;
  localparam int NMUL = NT * NT;

  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (in_valid && in_ready) cnt <= 8'd1;
    else if (cnt != 8'd0 && cnt <= 8'(NMUL)) cnt <= cnt + 8'd1;
    else cnt <= '0;
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 8'd0 && cnt <= 8'(NMUL)) |-> !in_ready); // R1
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0 || cnt == 8'(NMUL + 1)) |-> in_ready); // R1
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'(NMUL + 1)) |-> out_done); // R3
  AST_DONE_ONLY_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (cnt == 8'(NMUL + 1))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready) && !$past(in_valid)) |->
      ($stable(out_quot) && $stable(out_rem) && $stable(out_ovf))); // R7
endmodule

bind wide_fx_mul wfm_chk #(.OP_W(OP_W), .TILE_W(TILE_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/tb_wide_fx_mul.sv
module tb_wide_fx_mul;
  localparam int OW = 384;
  localparam int FW = 335;
  localparam int PW = 768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [OW-1:0] in_a = '0, in_b = '0;
  logic          out_done;
  logic [OW-1:0] out_quot;
  logic [FW-1:0] out_rem;
  logic          out_ovf;

  int n_chk = 0;
  int n_fail = 0;

  wide_fx_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_done(out_done), .out_quot(out_quot),
    .out_rem(out_rem), .out_ovf(out_ovf)
  );

  always #5 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [OW-1:0] a, input logic [OW-1:0] b);
    logic [PW-1:0] ea, eb;
    ea = PW'(a);
    eb = PW'(b);
    return ea * eb;
  endfunction

  function automatic logic [OW-1:0] rnd_op(input int keep_bits);
    logic [OW-1:0] v;
    v = '0;
    for (int w = 0; w < OW / 32; w++) v[w*32 +: 32] = $urandom();
    if (keep_bits < OW) v = v & ((({{(OW-1){1'b0}}, 1'b1}) << keep_bits) - 1'b1);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge with in_ready expected high; returns at the negedge of the done cycle.
  task automatic run_op(input logic [OW-1:0] a, input logic [OW-1:0] b, input bit junk);
    logic [PW-1:0] p;
    p = ref_mul(a, b);
    chk(in_ready == 1'b1, "R1 ready before request", PW'(in_ready), PW'(1));
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      in_valid = 1'b1;
      in_a = ~a;
      in_b = b ^ {OW{1'b1}};
    end else begin
      in_valid = 1'b0;
    end
    for (int k = 1; k <= 9; k++) begin
      chk(in_ready == 1'b0, "R1 busy not ready", PW'(in_ready), PW'(0));
      chk(out_done == 1'b0, junk ? "R2 no done while busy" : "R3 no early done",
          PW'(out_done), PW'(0));
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(out_done == 1'b1, "R3 done on tenth cycle", PW'(out_done), PW'(1));
    chk(in_ready == 1'b1, "R1 ready in done cycle", PW'(in_ready), PW'(1));
    chk(out_quot == p[718:335], junk ? "R2 R4 quotient" : "R4 quotient",
        PW'(out_quot), PW'(p[718:335]));
    chk(out_rem == p[334:0], junk ? "R2 R5 remainder" : "R5 remainder",
        PW'(out_rem), PW'(p[334:0]));
    chk(out_ovf == (|p[767:719]), "R6 overflow", PW'(out_ovf), PW'(|p[767:719]));
  endtask

  task automatic hold_check();
    logic [OW-1:0] q;
    logic [FW-1:0] r;
    logic          o;
    q = out_quot;
    r = out_rem;
    o = out_ovf;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_done == 1'b0, "R3 single pulse", PW'(out_done), PW'(0));
      chk(out_quot == q && out_rem == r && out_ovf == o, "R7 result held",
          PW'(out_quot), PW'(q));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [OW-1:0] ones, one_q;
    void'($urandom(32'd20240611));
    ones = {OW{1'b1}};
    one_q = OW'(1) << FW;

    repeat (3) @(negedge clk);
    // R8 reset state
    chk(in_ready == 1'b1, "R8 ready in reset", PW'(in_ready), PW'(1));
    chk(out_done == 1'b0, "R8 done in reset", PW'(out_done), PW'(0));
    chk(out_quot == '0 && out_rem == '0 && out_ovf == 1'b0, "R8 outputs zero",
        PW'(out_quot), PW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_done == 1'b0, "R8 after reset", PW'(in_ready), PW'(1));

    // Directed corners
    run_op(OW'(3), OW'(5), 1'b0); hold_check();          // R5 small remainder
    run_op(one_q, ones, 1'b0);    hold_check();          // R4 unit scale returns b
    run_op('0, ones, 1'b0);       hold_check();          // zero product
    run_op(ones, ones, 1'b0);     hold_check();          // R6 all-ones overflows
    run_op(ones, OW'(1) << (FW - 1), 1'b0); hold_check(); // R6 boundary case

    // R2 requests held during busy must be ignored
    run_op(rnd_op(360), rnd_op(355), 1'b1); hold_check();

    // R9 back-to-back: second request presented in the done cycle
    run_op(rnd_op(300), rnd_op(300), 1'b0);
    chk(out_done && in_ready, "R9 accept alongside done", PW'(in_ready), PW'(1));
    run_op(rnd_op(384), rnd_op(200), 1'b0);
    hold_check();

    // Constrained random
    for (int t = 0; t < 40; t++) begin
      int ka, kb;
      ka = 64 + int'($urandom_range(320));
      kb = 64 + int'($urandom_range(320));
      run_op(rnd_op(ka), rnd_op(kb), t[0]);
      if (t % 4 == 3) hold_check();
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule